// File: doc/BRIEF.md
# TDM Slot to Channel Remapper

The remapper sits between a 32-slot serial frame buffer and a set of 24 per-channel sample streams. Incoming frame bytes are stored, in arrival order, in a receive buffer that holds two halves of N frames each. When a half-complete event arrives, the block scans the first frame of the selected receive half for a 0x7F alignment marker. If it finds one, it updates a rotating slot offset. It then emits every channel byte of every frame in that half, with the channel and frame number attached.

The same event then rebuilds the selected transmit half. For each frame and channel, the block requests one byte from the channel sources. It writes that byte into the transmit slot the channel maps to, shifted by the current offset. Any consumer can read the rebuilt transmit frames at random from a byte-wide read port.

Channels occupy slots in descending groups of three, and every fourth slot is left empty. The receive side sees the line four slots later than the transmit side, so receive addressing adds a fixed skew of four slots. Transmit addressing does not.

Top module: `tdm_slot_remap`

## Requirements
- R1: After reset, rxOutValid, rxDone, txReqValid and txDone are low, the offset is 0, and every byte of the transmit buffer reads 0.
- R2: Each cycle with rxInValid high stores rxInByte at the next receive buffer address, starting at 0 after reset and wrapping after 64·N bytes. Frame f, slot s of half h (h=0 first, h=1 second) lies at address 32·N·h + 32·f + s.
- R3: A cycle with intEvt high while idle starts processing only if intStat[3:0] is nonzero. An event with intStat[3:0] = 0 produces no receive output, no transmit request and no change to the transmit buffer.
- R4: The receive half is the first when intStat[3] = 1 and the second otherwise. The transmit half is the first when intStat[0] = 1 and the second otherwise.
- R5: Only frame 0 of the selected receive half is scanned, at slots (4k+7) mod 32 for k = 0..7. A byte equal to 0x7F at such a slot sets the offset to 4k, and the highest such k wins. The offset keeps its value when no scanned slot holds the marker. A 0x7F byte in any other slot or frame has no effect.
- R6: Channel c (0..23) maps to slot map(c) = 4·(c div 3) + 2 − (c mod 3), giving 2,1,0,6,5,4,…,30,29,28.
- R7: The receive output delivers N·24 bytes in frame-major order, with channel ascending inside each frame. Each byte is taken from slot (map(c) + 4 + offset) mod 32 of frame f and is tagged with rxOutChan = c and rxOutFrame = f.
- R8: The transmit rebuild raises txReqValid with txReqChan = c and txReqFrame = f for N·24 cycles, in frame-major order. The byte presented on txChanByte in each such cycle is written to slot (map(c) + offset) mod 32 of frame f in the selected transmit half. All other transmit bytes keep their values.
- R9: rxDone is a one-cycle pulse that coincides with the last receive output (channel 23, frame N−1). txDone is a one-cycle pulse in the cycle after the last transmit write, by which time that write is readable.
- R10: Within one event, the transmit rebuild starts only after the last receive output has been issued, and it uses the offset found by that event's scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxInValid | input | 1 | Receive frame byte strobe |
| rxInByte | input | 8 | Receive frame byte |
| intEvt | input | 1 | Half-complete event strobe |
| intStat | input | 4 | Event status: bit 3 selects the receive half, bit 0 selects the transmit half |
| txChanByte | input | 8 | Channel byte answering the current transmit request |
| txRdAddr | input | log2(64·N) | Transmit buffer read address |
| rxOutValid | output | 1 | Receive channel byte valid |
| rxOutByte | output | 8 | Receive channel byte |
| rxOutChan | output | 5 | Channel of rxOutByte |
| rxOutFrame | output | log2(N) | Frame of rxOutByte |
| rxDone | output | 1 | Receive half finished |
| txReqValid | output | 1 | Transmit byte request |
| txReqChan | output | 5 | Requested channel |
| txReqFrame | output | log2(N) | Requested frame |
| txDone | output | 1 | Transmit half finished |
| txRdData | output | 8 | Transmit buffer byte at txRdAddr |

## Verification
The assertions assume that intEvt is raised only while the block is idle. Events that arrive during a rebuild would be lost, so that rule is checked as an input property. The bench therefore sends each event only after it has seen txDone from the previous one, or after a long idle wait for an ignored event. The bench also writes whole halves through the sequential receive port between events, so the half being scanned is never written while it is being processed.

// File: rtl/tdm_remap_pkg.sv
package tdm_remap_pkg;

  localparam int SLOT_COUNT = 32;
  localparam int SLOT_W     = $clog2(SLOT_COUNT);
  localparam int CHAN_COUNT = 24;
  localparam int CHAN_W     = 5;
  localparam int GROUP_LEN  = 3;
  localparam int GROUP_STEP = 4;
  localparam int MARK_COUNT = 8;
  localparam int MARK_W     = $clog2(MARK_COUNT);
  localparam int RX_SKEW    = 4;
  localparam int BYTE_W     = 8;
  localparam int STAT_W     = 4;
  localparam int RX_SEL_BIT = 3;
  localparam int TX_SEL_BIT = 0;
  localparam logic [BYTE_W-1:0] MARKER = 8'h7F;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_RXMV,
    ST_TXMV
  } remapState_t;

  typedef struct packed {
    logic scanEn;
    logic rxMove;
    logic rxLast;
    logic txMove;
    logic txLast;
    logic rxHalf;
    logic txHalf;
  } remapStb_t;

  // Slot carrying channel c: descending triples, fourth slot of each group empty.
  function automatic logic [SLOT_W-1:0] chanSlot(input logic [CHAN_W-1:0] c);
    int grp;
    int pos;
    grp = int'(c) / GROUP_LEN;
    pos = int'(c) % GROUP_LEN;
    return SLOT_W'(GROUP_STEP * grp + (GROUP_LEN - 1) - pos);
  endfunction

  // Slot inspected for marker candidate k; truncation gives the modulo wrap.
  function automatic logic [SLOT_W-1:0] markSlot(input logic [MARK_W-1:0] k);
    return SLOT_W'(GROUP_STEP * int'(k) + (GROUP_STEP - 1) + RX_SKEW);
  endfunction

endpackage

// File: rtl/tdm_remap_ctrl.sv
module tdm_remap_ctrl
  import tdm_remap_pkg::*;
#(
  parameter int FRAMES  = 8,
  parameter int FRAME_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               intEvt,
  input  logic [STAT_W-1:0]  intStat,
  output remapStb_t          stb,
  output logic [CHAN_W-1:0]  idxChan,
  output logic [FRAME_W-1:0] idxFrame,
  output logic [MARK_W-1:0]  idxScan,
  output logic               busy
);

  remapState_t        stateQ;
  logic [CHAN_W-1:0]  chanQ;
  logic [FRAME_W-1:0] frameQ;
  logic [MARK_W-1:0]  scanQ;
  logic               rxHalfQ;
  logic               txHalfQ;
  logic               lastChan;
  logic               lastFrame;
  logic               lastScan;
  logic               evtGo;

  always_comb begin
    lastChan   = (chanQ == CHAN_W'(CHAN_COUNT - 1));
    lastFrame  = (frameQ == FRAME_W'(FRAMES - 1));
    lastScan   = (scanQ == MARK_W'(MARK_COUNT - 1));
    evtGo      = intEvt && (|intStat);
    stb.scanEn = (stateQ == ST_SCAN);
    stb.rxMove = (stateQ == ST_RXMV);
    stb.txMove = (stateQ == ST_TXMV);
    stb.rxLast = (stateQ == ST_RXMV) && lastChan && lastFrame;
    stb.txLast = (stateQ == ST_TXMV) && lastChan && lastFrame;
    stb.rxHalf = rxHalfQ;
    stb.txHalf = txHalfQ;
    idxChan    = chanQ;
    idxFrame   = frameQ;
    idxScan    = scanQ;
    busy       = (stateQ != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      chanQ   <= '0;
      frameQ  <= '0;
      scanQ   <= '0;
      rxHalfQ <= 1'b0;
      txHalfQ <= 1'b0;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (evtGo) begin
            stateQ  <= ST_SCAN;
            scanQ   <= '0;
            rxHalfQ <= !intStat[RX_SEL_BIT];
            txHalfQ <= !intStat[TX_SEL_BIT];
          end
        end
        ST_SCAN: begin
          scanQ <= scanQ + 1'b1;
          if (lastScan) begin
            stateQ <= ST_RXMV;
            chanQ  <= '0;
            frameQ <= '0;
          end
        end
        ST_RXMV, ST_TXMV: begin
          if (lastChan) begin
            chanQ <= '0;
            if (lastFrame) begin
              frameQ <= '0;
              stateQ <= (stateQ == ST_RXMV) ? ST_TXMV : ST_IDLE;
            end else begin
              frameQ <= frameQ + 1'b1;
            end
          end else begin
            chanQ <= chanQ + 1'b1;
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tdm_remap_dp.sv
module tdm_remap_dp
  import tdm_remap_pkg::*;
#(
  parameter int FRAMES  = 8,
  parameter int FRAME_W = 3,
  parameter int ADDR_W  = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxInValid,
  input  logic [BYTE_W-1:0]  rxInByte,
  input  remapStb_t          stb,
  input  logic [CHAN_W-1:0]  idxChan,
  input  logic [FRAME_W-1:0] idxFrame,
  input  logic [MARK_W-1:0]  idxScan,
  input  logic [BYTE_W-1:0]  txChanByte,
  input  logic [ADDR_W-1:0]  txRdAddr,
  output logic               rxOutValid,
  output logic [BYTE_W-1:0]  rxOutByte,
  output logic [CHAN_W-1:0]  rxOutChan,
  output logic [FRAME_W-1:0] rxOutFrame,
  output logic               rxDone,
  output logic               txDone,
  output logic [BYTE_W-1:0]  txRdData,
  output logic [SLOT_W-1:0]  offsetQ
);

  localparam int HALF_BYTES = FRAMES * SLOT_COUNT;
  localparam int BUF_BYTES  = 2 * HALF_BYTES;

  logic [BYTE_W-1:0] rxMem [BUF_BYTES];
  logic [BYTE_W-1:0] txMem [BUF_BYTES];
  logic [ADDR_W-1:0] rxWrPtr;
  logic [ADDR_W-1:0] scanAddr;
  logic [ADDR_W-1:0] rdAddr;
  logic [ADDR_W-1:0] txWrAddr;
  logic [SLOT_W-1:0] rxSlot;
  logic [SLOT_W-1:0] txSlot;
  logic [BYTE_W-1:0] rdByte;
  logic              markHit;

  function automatic logic [ADDR_W-1:0] bufAddr(input logic h,
                                                input logic [FRAME_W-1:0] f,
                                                input logic [SLOT_W-1:0] s);
    return ADDR_W'(int'(h) * HALF_BYTES + int'(f) * SLOT_COUNT + int'(s));
  endfunction

  always_comb begin
    scanAddr = bufAddr(stb.rxHalf, '0, markSlot(idxScan));
    rxSlot   = chanSlot(idxChan) + SLOT_W'(RX_SKEW) + offsetQ;
    txSlot   = chanSlot(idxChan) + offsetQ;
    rdAddr   = stb.scanEn ? scanAddr : bufAddr(stb.rxHalf, idxFrame, rxSlot);
    txWrAddr = bufAddr(stb.txHalf, idxFrame, txSlot);
    rdByte   = rxMem[rdAddr];
    markHit  = stb.scanEn && (rdByte == MARKER);
    txRdData = txMem[txRdAddr];
  end

  // Receive frame store, filled strictly in arrival order.
  always_ff @(posedge clk) begin
    if (rxInValid) rxMem[rxWrPtr] <= rxInByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxWrPtr <= '0;
    end else if (rxInValid) begin
      rxWrPtr <= (rxWrPtr == ADDR_W'(BUF_BYTES - 1)) ? '0 : rxWrPtr + 1'b1;
    end
  end

  // Alignment offset: later candidates overwrite earlier ones.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      offsetQ <= '0;
    end else if (markHit) begin
      offsetQ <= SLOT_W'({idxScan, 2'b00});
    end
  end

  // Transmit frame store, cleared by reset.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < BUF_BYTES; i++) txMem[i] <= '0;
    end else if (stb.txMove) begin
      txMem[txWrAddr] <= txChanByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxOutValid <= 1'b0;
      rxOutByte  <= '0;
      rxOutChan  <= '0;
      rxOutFrame <= '0;
      rxDone     <= 1'b0;
      txDone     <= 1'b0;
    end else begin
      rxOutValid <= stb.rxMove;
      rxDone     <= stb.rxLast;
      txDone     <= stb.txLast;
      if (stb.rxMove) begin
        rxOutByte  <= rdByte;
        rxOutChan  <= idxChan;
        rxOutFrame <= idxFrame;
      end
    end
  end

endmodule

// File: rtl/tdm_slot_remap.sv
module tdm_slot_remap
  import tdm_remap_pkg::*;
#(
  parameter  int FRAMES  = 8,
  localparam int FRAME_W = $clog2(FRAMES),
  localparam int ADDR_W  = $clog2(2 * FRAMES * SLOT_COUNT)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               rxInValid,
  input  logic [BYTE_W-1:0]  rxInByte,
  input  logic               intEvt,
  input  logic [STAT_W-1:0]  intStat,
  input  logic [BYTE_W-1:0]  txChanByte,
  input  logic [ADDR_W-1:0]  txRdAddr,
  output logic               rxOutValid,
  output logic [BYTE_W-1:0]  rxOutByte,
  output logic [CHAN_W-1:0]  rxOutChan,
  output logic [FRAME_W-1:0] rxOutFrame,
  output logic               rxDone,
  output logic               txReqValid,
  output logic [CHAN_W-1:0]  txReqChan,
  output logic [FRAME_W-1:0] txReqFrame,
  output logic               txDone,
  output logic [BYTE_W-1:0]  txRdData
);

  remapStb_t          stb;
  logic [CHAN_W-1:0]  idxChan;
  logic [FRAME_W-1:0] idxFrame;
  logic [MARK_W-1:0]  idxScan;
  logic [SLOT_W-1:0]  offsetQ;
  logic               busy;

  tdm_remap_ctrl #(.FRAMES(FRAMES), .FRAME_W(FRAME_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .intEvt   (intEvt),
    .intStat  (intStat),
    .stb      (stb),
    .idxChan  (idxChan),
    .idxFrame (idxFrame),
    .idxScan  (idxScan),
    .busy     (busy)
  );

  tdm_remap_dp #(.FRAMES(FRAMES), .FRAME_W(FRAME_W), .ADDR_W(ADDR_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .rxInValid  (rxInValid),
    .rxInByte   (rxInByte),
    .stb        (stb),
    .idxChan    (idxChan),
    .idxFrame   (idxFrame),
    .idxScan    (idxScan),
    .txChanByte (txChanByte),
    .txRdAddr   (txRdAddr),
    .rxOutValid (rxOutValid),
    .rxOutByte  (rxOutByte),
    .rxOutChan  (rxOutChan),
    .rxOutFrame (rxOutFrame),
    .rxDone     (rxDone),
    .txDone     (txDone),
    .txRdData   (txRdData),
    .offsetQ    (offsetQ)
  );

  assign txReqValid = stb.txMove;
  assign txReqChan  = idxChan;
  assign txReqFrame = idxFrame;

endmodule

// File: rtl/tdm_remap_chk.sv
module tdm_remap_chk
  import tdm_remap_pkg::*;
#(
  parameter int FRAMES  = 8,
  parameter int FRAME_W = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               intEvt,
  input logic [STAT_W-1:0]  intStat,
  input logic               busy,
  input remapStb_t          stb,
  input logic [SLOT_W-1:0]  offsetQ,
  input logic               rxOutValid,
  input logic [CHAN_W-1:0]  rxOutChan,
  input logic [FRAME_W-1:0] rxOutFrame,
  input logic               rxDone,
  input logic               txReqValid,
  input logic               txDone
);

  AST_EVT_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    intEvt |-> !busy); // R3

  AST_EMPTY_EVT_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && intEvt && intStat == '0) |=> !busy); // R3

  AST_OFFSET_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.scanEn |=> $stable(offsetQ)); // R5

  AST_RX_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    rxOutValid |-> rxOutChan < CHAN_W'(CHAN_COUNT)); // R7

  AST_RX_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (rxOutValid && $past(rxOutValid) && rxOutChan != '0)
      |-> rxOutChan == CHAN_W'($past(rxOutChan) + 1'b1)); // R7

  AST_TX_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    txReqValid |-> busy); // R8

  AST_RXDONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> !rxDone); // R9

  AST_TXDONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    txDone |=> !txDone); // R9

  AST_RXDONE_LAST: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |-> (rxOutValid && rxOutChan == CHAN_W'(CHAN_COUNT - 1)
                && rxOutFrame == FRAME_W'(FRAMES - 1))); // R9

  AST_TX_AFTER_RX: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txReqValid) |-> $past(stb.rxLast)); // R10

endmodule

bind tdm_slot_remap tdm_remap_chk #(.FRAMES(FRAMES), .FRAME_W(FRAME_W)) i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .intEvt     (intEvt),
  .intStat    (intStat),
  .busy       (busy),
  .stb        (stb),
  .offsetQ    (offsetQ),
  .rxOutValid (rxOutValid),
  .rxOutChan  (rxOutChan),
  .rxOutFrame (rxOutFrame),
  .rxDone     (rxDone),
  .txReqValid (txReqValid),
  .txDone     (txDone)
);

// File: tb/test_tdm_slot_remap.sv
`timescale 1ns/1ps
module test_tdm_slot_remap;

  localparam int N      = 8;
  localparam int FW     = 3;
  localparam int AW     = 9;
  localparam int HALF   = N * 32;
  localparam int BUFSZ  = 2 * HALF;
  localparam int PERHALF = N * 24;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rxInValid = 1'b0;
  logic [7:0]    rxInByte = '0;
  logic          intEvt = 1'b0;
  logic [3:0]    intStat = '0;
  logic [7:0]    txChanByte;
  logic [AW-1:0] txRdAddr = '0;
  logic          rxOutValid;
  logic [7:0]    rxOutByte;
  logic [4:0]    rxOutChan;
  logic [FW-1:0] rxOutFrame;
  logic          rxDone;
  logic          txReqValid;
  logic [4:0]    txReqChan;
  logic [FW-1:0] txReqFrame;
  logic          txDone;
  logic [7:0]    txRdData;

  logic [7:0] rxModel [BUFSZ];
  logic [7:0] txModel [BUFSZ];
  int offModel = 0;
  int txSeed = 0;
  int errs = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] txPat(int seed, int c, int f);
    return 8'(seed * 31 + c * 5 + f * 67 + 1);
  endfunction

  assign txChanByte = txPat(txSeed, int'(txReqChan), int'(txReqFrame));

  tdm_slot_remap #(.FRAMES(N)) i_tdm_slot_remap (
    .clk(clk), .rstN(rstN), .rxInValid(rxInValid), .rxInByte(rxInByte),
    .intEvt(intEvt), .intStat(intStat), .txChanByte(txChanByte),
    .txRdAddr(txRdAddr), .rxOutValid(rxOutValid), .rxOutByte(rxOutByte),
    .rxOutChan(rxOutChan), .rxOutFrame(rxOutFrame), .rxDone(rxDone),
    .txReqValid(txReqValid), .txReqChan(txReqChan), .txReqFrame(txReqFrame),
    .txDone(txDone), .txRdData(txRdData)
  );

  // Channel to slot rule from R6.
  function automatic int slotOf(int c);
    return 4 * (c / 3) + 2 - (c % 3);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic checkTxBuf(input string req, input string what);
    int bad = 0;
    int fa = 0;
    int fe = 0;
    for (int a = 0; a < BUFSZ; a++) begin
      txRdAddr = AW'(a);
      #0.1;
      if (txRdData !== txModel[a]) begin
        if (bad == 0) begin
          fa = int'(txRdData);
          fe = int'(txModel[a]);
        end
        bad++;
      end
    end
    check(bad == 0, req, what, fa, fe);
  endtask

  // Writes both halves in order; markers are bit masks of candidate k per half.
  task automatic fillHalves(input int seed, input int mark0, input int mark1);
    for (int h = 0; h < 2; h++) begin
      for (int i = 0; i < HALF; i++) begin
        logic [7:0] b;
        int m;
        b = 8'((seed * 13) ^ (i * 7) ^ (h * 91)) | 8'h80;
        m = (h == 0) ? mark0 : mark1;
        for (int k = 0; k < 8; k++)
          if (m[k] && i == ((4 * k + 7) % 32)) b = 8'h7F;
        if (i == 5 || i == 32 + 7) b = 8'h7F;   // R5 stray markers, not scanned
        @(negedge clk);
        rxInValid = 1'b1;
        rxInByte  = b;
        rxModel[h * HALF + i] = b;
      end
    end
    @(negedge clk);
    rxInValid = 1'b0;
  endtask

  task automatic runEvent(input string name, input logic [3:0] stat, input int seed);
    int hr, ht, rxCnt, rxBad, doneCnt, doneOk, txCnt, txOrdBad, fa, fe, cyc;
    bit seenTx;
    hr = stat[3] ? 0 : 1;
    ht = stat[0] ? 0 : 1;
    txSeed = seed;
    for (int k = 0; k < 8; k++)
      if (rxModel[hr * HALF + ((4 * k + 7) % 32)] == 8'h7F) offModel = 4 * k;
    rxCnt = 0; rxBad = 0; doneCnt = 0; doneOk = 0; txCnt = 0; txOrdBad = 0;
    fa = 0; fe = 0; seenTx = 0;
    @(negedge clk);
    intEvt = 1'b1;
    intStat = stat;
    @(negedge clk);
    intEvt = 1'b0;
    intStat = '0;
    for (cyc = 0; cyc < 2000 && !seenTx; cyc++) begin
      if (rxOutValid) begin
        int c, f, ex;
        c = rxCnt % 24;
        f = rxCnt / 24;
        ex = int'(rxModel[hr * HALF + f * 32 + ((slotOf(c) + 4 + offModel) % 32)]);
        if (int'(rxOutChan) != c || int'(rxOutFrame) != f || int'(rxOutByte) != ex) begin
          if (rxBad == 0) begin fa = int'(rxOutByte); fe = ex; end
          rxBad++;
        end
        if (rxDone) begin
          doneCnt++;
          if (rxCnt == PERHALF - 1) doneOk = 1;
        end
        rxCnt++;
      end else if (rxDone) begin
        doneCnt++;
      end
      if (txReqValid) begin
        int c, f;
        c = int'(txReqChan);
        f = int'(txReqFrame);
        if (c != txCnt % 24 || f != txCnt / 24) txOrdBad++;
        txModel[ht * HALF + f * 32 + ((slotOf(c) + offModel) % 32)] = txPat(seed, c, f);
        txCnt++;
      end
      if (txDone) seenTx = 1;
      @(negedge clk);
    end
    check(seenTx, "R9", {name, " txDone seen"}, int'(seenTx), 1);
    check(rxCnt == PERHALF, "R9", {name, " rx output count"}, rxCnt, PERHALF);
    check(rxBad == 0, "R2 R4 R5 R6 R7", {name, " rx bytes"}, fa, fe);
    check(doneCnt == 1 && doneOk == 1, "R9", {name, " rxDone with last"}, doneCnt, 1);
    check(txCnt == PERHALF && txOrdBad == 0, "R8", {name, " tx requests"}, txCnt, PERHALF);
    checkTxBuf("R4 R8 R10", {name, " tx buffer"});
  endtask

  task automatic t_reset();
    check(!rxOutValid && !rxDone, "R1", "rx outputs after reset", int'(rxOutValid), 0);
    check(!txReqValid && !txDone, "R1", "tx outputs after reset", int'(txReqValid), 0);
    checkTxBuf("R1", "tx buffer zero after reset");
  endtask

  task automatic t_basic();
    fillHalves(1, 0, 0);
    runEvent("basic", 4'b1001, 3);     // R4 rx first, tx first, offset 0
  endtask

  task automatic t_marker();
    fillHalves(2, 0, 8'b0000_0100);
    runEvent("marker", 4'b0010, 5);    // R3 bit1 triggers; R5 offset 8, second halves
  endtask

  task automatic t_multi();
    fillHalves(3, 8'b1000_0010, 0);
    runEvent("multi", 4'b1000, 7);     // R5 highest k wins (k=7 wraps to slot 3); R10
  endtask

  task automatic t_hold();
    fillHalves(4, 8'b0010_0000, 0);
    runEvent("hold", 4'b0001, 9);      // R5 marker only in unselected half: offset kept
  endtask

  task automatic t_ignore();
    int seen = 0;
    @(negedge clk);
    intEvt = 1'b1;
    intStat = 4'b0000;
    @(negedge clk);
    intEvt = 1'b0;
    for (int i = 0; i < 80; i++) begin
      if (rxOutValid || txReqValid || rxDone || txDone) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R3", "empty event activity", seen, 0);
    checkTxBuf("R3", "tx buffer after empty event");
  endtask

  initial begin
    for (int a = 0; a < BUFSZ; a++) begin
      txModel[a] = '0;
      rxModel[a] = '0;
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_marker();
    t_multi();
    t_ignore();
    t_hold();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #1ms;
    errs++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule